// File: doc/BRIEF.md
# Smoke Sample Rate Scheduler

This block decides when a low-power optical smoke detector powers up its sensing path. All timing comes from a slow tick input of roughly 10.4 ms. Each tick counts down an interval. When the interval runs out, the block issues a one-cycle sample strobe. The sensing path answers with a result pulse that says whether the reading looked like smoke.

Consecutive positive readings shorten the interval step by step. The third positive in a row latches a local alarm, and sampling then continues at the fast rate until enough negative readings in a row clear it. A push-button test and a remote alarm input each select their own sampling rate. Battery and chamber checks are issued together with the plain standby samples.

Period rule: the countdown restarts with the period of the current mode at three points. These are each sample strobe, the second cycle after each result pulse, and any edge where the mode changes. The strobe follows the tick that completes that many ticks.

Top module: `smoke_sample_sched`

## Requirements
- R1: While `rst` is high, all outputs are low. After reset the block is in standby, and the first strobe comes on the P_STBY-th tick after reset is released.
- R2: In standby (no hits counted, no alarm, no test, no remote), the interval is P_STBY ticks (default 1024, about 10.7 s).
- R3: One hit in a row gives an interval of P_ONE ticks (default 192). Two hits in a row give P_TWO ticks (default 96). A miss before the alarm sets the count to zero, which returns the block to standby.
- R4: ALARM_CNT hits in a row (default 3) raise `local_alarm` in the cycle after the result pulse. While the alarm lasts, the interval is P_ALARM ticks (default 96).
- R5: During the alarm, CLEAR_CNT misses in a row (default 1) clear `local_alarm` and return the block to standby. A hit resets this miss count.
- R6: While `pb_test` is high, the interval is P_PB_MISS ticks (default 32) until two hits have been seen during the test, and P_PB_HIT ticks (default 24) after that. Results taken during the test leave the hit ladder and the alarm unchanged. The test hit count clears when `pb_test` falls.
- R7: With `remote_in` high, no local alarm and a zero hit count, the interval is P_REMOTE ticks (default 768). `remote_only` is high while `remote_in` is high and there is no local alarm.
- R8: Only strobes taken in standby count as slots. `batt_chk` pulses with every BATT_EVERY-th slot (default 8), and `cham_chk` pulses with every CHAM_EVERY-th slot (default 4), in the same cycle as `sample_strobe`. Counting starts at reset.
- R9: The modes rank as follows: push-button test first, then local alarm, then a non-zero hit count, then remote, then standby. A change of mode restarts the countdown with the new period.
- R10: `sample_strobe` is a one-cycle pulse in the cycle after the tick that completes the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-base pulse (~10.4 ms) |
| res_vld | input | 1 | Result pulse from the sensing path |
| res_hit | input | 1 | With res_vld: 1 = reading above the smoke limit |
| pb_test | input | 1 | Push-button test request (level) |
| remote_in | input | 1 | Alarm signalled by another detector (level) |
| sample_strobe | output | 1 | Power up and sample the smoke sensor |
| batt_chk | output | 1 | Run the low-battery check with this sample |
| cham_chk | output | 1 | Run the chamber-integrity check with this sample |
| local_alarm | output | 1 | Local smoke alarm latched |
| remote_only | output | 1 | Remote alarm present with no local alarm |

## Verification
The bench sweeps every six-reading hit/miss pattern through a small configuration and keeps a running model of the ladder. Against that model it checks the measured tick count of every interval and every alarm edge. A design that did not reset the count on a miss, or that needed one hit too many or too few, would sample at the wrong interval or raise the alarm at the wrong reading. The model also tracks the standby slot counters over the whole run. This catches check pulses that are off by one, and non-standby strobes that wrongly advance the slot count. Directed phases combine a remote alarm with a rising hit count, and a push-button test with a latched alarm. In these phases, a wrong priority between modes shows up as a wrong interval, and a ladder disturbed by test results shows up as an alarm state change.

// File: rtl/smoke_sched_pkg.sv
package smoke_sched_pkg;

  typedef enum logic [2:0] {
    M_STBY,
    M_ONE,
    M_TWO,
    M_ALARM,
    M_REMOTE,
    M_PB,
    M_PBHIT
  } smk_mode_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/smoke_ladder.sv
module smoke_ladder
  import smoke_sched_pkg::*;
#(
  parameter int ALARM_CNT = 3,
  parameter int CLEAR_CNT = 1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      res_vld,
  input  logic      res_hit,
  input  logic      pb_test,
  input  logic      remote_in,
  output smk_mode_t mode,
  output logic      local_alarm,
  output logic      remote_only
);
  localparam int CW = $clog2(ALARM_CNT + 1);
  localparam int KW = $clog2(CLEAR_CNT + 1);

  logic [CW-1:0] hit_cnt;
  logic [KW-1:0] miss_cnt;
  logic [1:0]    pb_hits;
  logic          alarm_q;
  logic          remote_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_cnt  <= '0;
      miss_cnt <= '0;
      pb_hits  <= '0;
      alarm_q  <= 1'b0;
      remote_q <= 1'b0;
    end else begin
      remote_q <= remote_in && !alarm_q;
      if (!pb_test) pb_hits <= '0;
      if (res_vld) begin
        if (pb_test) begin
          if (res_hit && pb_hits != 2'd2) pb_hits <= pb_hits + 2'd1;
        end else if (alarm_q) begin
          if (res_hit) begin
            miss_cnt <= '0;
          end else if (miss_cnt == KW'(CLEAR_CNT - 1)) begin
            alarm_q  <= 1'b0;
            hit_cnt  <= '0;
            miss_cnt <= '0;
          end else begin
            miss_cnt <= miss_cnt + 1'b1;
          end
        end else if (res_hit) begin
          if (hit_cnt == CW'(ALARM_CNT - 1)) begin
            alarm_q  <= 1'b1;
            hit_cnt  <= '0;
            miss_cnt <= '0;
          end else begin
            hit_cnt <= hit_cnt + 1'b1;
          end
        end else begin
          hit_cnt <= '0;
        end
      end
    end
  end

  always_comb begin
    if (pb_test)             mode = (pb_hits == 2'd2) ? M_PBHIT : M_PB;
    else if (alarm_q)        mode = M_ALARM;
    else if (hit_cnt == 1)   mode = M_ONE;
    else if (hit_cnt != 0)   mode = M_TWO;
    else if (remote_in)      mode = M_REMOTE;
    else                     mode = M_STBY;
  end

  assign local_alarm = alarm_q;
  assign remote_only = remote_q;

  AST_ALARM_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_q) |-> $past(res_vld && res_hit && !pb_test)); // R4
  AST_TEST_KEEPS_ALARM: assert property (@(posedge clk) disable iff (rst)
    $past(pb_test) |-> $stable(alarm_q)); // R6
  AST_REMOTE_FLAG: assert property (@(posedge clk) disable iff (rst)
    remote_q |-> $past(remote_in)); // R7

endmodule

// File: rtl/smoke_interval.sv
module smoke_interval
  import smoke_sched_pkg::*;
#(
  parameter int TW        = 10,
  parameter int P_STBY    = 1024,
  parameter int P_ONE     = 192,
  parameter int P_TWO     = 96,
  parameter int P_ALARM   = 96,
  parameter int P_PB_HIT  = 24,
  parameter int P_PB_MISS = 32,
  parameter int P_REMOTE  = 768
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      res_vld,
  input  smk_mode_t mode,
  output logic      fire,
  output logic      sample_strobe
);
  logic [TW-1:0] tmr;
  logic [TW-1:0] per;
  logic          rl_q;
  smk_mode_t     mode_q;
  logic          strobe_q;
  logic          reload;

  always_comb begin
    case (mode)
      M_ONE:    per = TW'(P_ONE);
      M_TWO:    per = TW'(P_TWO);
      M_ALARM:  per = TW'(P_ALARM);
      M_REMOTE: per = TW'(P_REMOTE);
      M_PB:     per = TW'(P_PB_MISS);
      M_PBHIT:  per = TW'(P_PB_HIT);
      default:  per = TW'(P_STBY);
    endcase
  end

  assign reload = rl_q || (mode != mode_q);
  assign fire   = !reload && tick && (tmr <= TW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr      <= TW'(P_STBY);
      rl_q     <= 1'b0;
      mode_q   <= M_STBY;
      strobe_q <= 1'b0;
    end else begin
      rl_q     <= res_vld;
      mode_q   <= mode;
      strobe_q <= fire;
      if (reload || fire) tmr <= per;
      else if (tick)      tmr <= tmr - 1'b1;
    end
  end

  assign sample_strobe = strobe_q;

  AST_STROBE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    strobe_q |-> $past(tick)); // R10

endmodule

// File: rtl/smoke_slot_checks.sv
module smoke_slot_checks
  import smoke_sched_pkg::*;
#(
  parameter int BATT_EVERY = 8,
  parameter int CHAM_EVERY = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      fire,
  input  smk_mode_t mode,
  input  logic      sample_strobe,
  output logic      batt_chk,
  output logic      cham_chk
);
  localparam int BW = $clog2(BATT_EVERY + 1);
  localparam int HW = $clog2(CHAM_EVERY + 1);

  logic [BW-1:0] bslot;
  logic [HW-1:0] cslot;
  logic          batt_q, cham_q;
  logic          stby_fire;

  assign stby_fire = fire && (mode == M_STBY);

  always_ff @(posedge clk) begin
    if (rst) begin
      bslot  <= '0;
      cslot  <= '0;
      batt_q <= 1'b0;
      cham_q <= 1'b0;
    end else begin
      batt_q <= stby_fire && (bslot == BW'(BATT_EVERY - 1));
      cham_q <= stby_fire && (cslot == HW'(CHAM_EVERY - 1));
      if (stby_fire) begin
        bslot <= (bslot == BW'(BATT_EVERY - 1)) ? '0 : bslot + 1'b1;
        cslot <= (cslot == HW'(CHAM_EVERY - 1)) ? '0 : cslot + 1'b1;
      end
    end
  end

  assign batt_chk = batt_q;
  assign cham_chk = cham_q;

  AST_CHK_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    (batt_q || cham_q) |-> sample_strobe); // R8
  AST_CHK_ONLY_STBY: assert property (@(posedge clk) disable iff (rst)
    (batt_q || cham_q) |-> $past(mode == M_STBY)); // R8

endmodule

// File: rtl/smoke_sample_sched.sv
module smoke_sample_sched
  import smoke_sched_pkg::*;
#(
  parameter int P_STBY     = 1024,
  parameter int P_ONE      = 192,
  parameter int P_TWO      = 96,
  parameter int P_ALARM    = 96,
  parameter int P_PB_HIT   = 24,
  parameter int P_PB_MISS  = 32,
  parameter int P_REMOTE   = 768,
  parameter int ALARM_CNT  = 3,
  parameter int CLEAR_CNT  = 1,
  parameter int BATT_EVERY = 8,
  parameter int CHAM_EVERY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic res_vld,
  input  logic res_hit,
  input  logic pb_test,
  input  logic remote_in,
  output logic sample_strobe,
  output logic batt_chk,
  output logic cham_chk,
  output logic local_alarm,
  output logic remote_only
);
  localparam int P_MAX = imax(imax(imax(P_STBY, P_ONE), imax(P_TWO, P_ALARM)),
                              imax(imax(P_PB_HIT, P_PB_MISS), P_REMOTE));
  localparam int TW = $clog2(P_MAX + 1);

  smk_mode_t mode;
  logic      fire;

  smoke_ladder #(.ALARM_CNT(ALARM_CNT), .CLEAR_CNT(CLEAR_CNT)) u_ladder (
    .clk(clk), .rst(rst), .res_vld(res_vld), .res_hit(res_hit),
    .pb_test(pb_test), .remote_in(remote_in), .mode(mode),
    .local_alarm(local_alarm), .remote_only(remote_only)
  );

  smoke_interval #(
    .TW(TW), .P_STBY(P_STBY), .P_ONE(P_ONE), .P_TWO(P_TWO), .P_ALARM(P_ALARM),
    .P_PB_HIT(P_PB_HIT), .P_PB_MISS(P_PB_MISS), .P_REMOTE(P_REMOTE)
  ) u_interval (
    .clk(clk), .rst(rst), .tick(tick), .res_vld(res_vld), .mode(mode),
    .fire(fire), .sample_strobe(sample_strobe)
  );

  smoke_slot_checks #(.BATT_EVERY(BATT_EVERY), .CHAM_EVERY(CHAM_EVERY)) u_checks (
    .clk(clk), .rst(rst), .fire(fire), .mode(mode),
    .sample_strobe(sample_strobe), .batt_chk(batt_chk), .cham_chk(cham_chk)
  );

endmodule

// File: tb/smoke_sample_sched_bench.sv
module smoke_sample_sched_bench;
  localparam int P_STBY = 16, P_ONE = 8, P_TWO = 4, P_ALARM = 5;
  localparam int P_PB_HIT = 2, P_PB_MISS = 3, P_REMOTE = 6;
  localparam int ALARM_CNT = 3, CLEAR_CNT = 2, BATT_EVERY = 8, CHAM_EVERY = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, res_vld = 1'b0, res_hit = 1'b0, pb_test = 1'b0, remote_in = 1'b0;
  logic sample_strobe, batt_chk, cham_chk, local_alarm, remote_only;

  always #2 clk = ~clk;

  smoke_sample_sched #(
    .P_STBY(P_STBY), .P_ONE(P_ONE), .P_TWO(P_TWO), .P_ALARM(P_ALARM),
    .P_PB_HIT(P_PB_HIT), .P_PB_MISS(P_PB_MISS), .P_REMOTE(P_REMOTE),
    .ALARM_CNT(ALARM_CNT), .CLEAR_CNT(CLEAR_CNT),
    .BATT_EVERY(BATT_EVERY), .CHAM_EVERY(CHAM_EVERY)
  ) u_smoke_sample_sched (
    .clk(clk), .rst(rst), .tick(tick), .res_vld(res_vld), .res_hit(res_hit),
    .pb_test(pb_test), .remote_in(remote_in), .sample_strobe(sample_strobe),
    .batt_chk(batt_chk), .cham_chk(cham_chk), .local_alarm(local_alarm),
    .remote_only(remote_only)
  );

  int total = 0, fails = 0, cyc = 0;
  int m_cnt = 0, m_clr = 0, m_hits = 0, m_bslot = 0, m_cslot = 0;
  bit m_alarm = 0;
  bit seen_s, seen_b, seen_c;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      fails = fails + 1;
      total = total + 1;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_per();
    if (pb_test)        return (m_hits >= 2) ? P_PB_HIT : P_PB_MISS;
    if (m_alarm)        return P_ALARM;
    if (m_cnt == 1)     return P_ONE;
    if (m_cnt >= 2)     return P_TWO;
    if (remote_in)      return P_REMOTE;
    return P_STBY;
  endfunction

  function automatic bit is_stby();
    return !pb_test && !m_alarm && m_cnt == 0 && !remote_in;
  endfunction

  task automatic step_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    seen_s = sample_strobe;
    seen_b = batt_chk;
    seen_c = cham_chk;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_sample(input string req);
    int n = 0;
    int ep = exp_per();
    bit st = is_stby();
    bit eb = st && (m_bslot == BATT_EVERY - 1);
    bit ec = st && (m_cslot == CHAM_EVERY - 1);
    do begin
      step_tick();
      n++;
    end while (!seen_s && n < 100);
    chk(n == ep, req, n, ep);
    chk(seen_b == eb, "R8 batt", int'(seen_b), int'(eb));
    chk(seen_c == ec, "R8 cham", int'(seen_c), int'(ec));
    if (st) begin
      m_bslot = (m_bslot + 1) % BATT_EVERY;
      m_cslot = (m_cslot + 1) % CHAM_EVERY;
    end
  endtask

  task automatic respond(input bit hit);
    res_vld = 1'b1;
    res_hit = hit;
    @(negedge clk);
    res_vld = 1'b0;
    res_hit = 1'b0;
    if (pb_test) begin
      if (hit && m_hits < 2) m_hits++;
    end else if (m_alarm) begin
      if (hit) m_clr = 0;
      else if (m_clr == CLEAR_CNT - 1) begin m_alarm = 0; m_cnt = 0; m_clr = 0; end
      else m_clr++;
    end else if (hit) begin
      if (m_cnt == ALARM_CNT - 1) begin m_alarm = 1; m_cnt = 0; m_clr = 0; end
      else m_cnt++;
    end else m_cnt = 0;
    repeat (2) @(negedge clk);
    chk(local_alarm == m_alarm, m_alarm ? "R4 alarm" : "R5 alarm", int'(local_alarm), int'(m_alarm));
  endtask

  function automatic string tag_for();
    if (pb_test) return "R6 period";
    if (m_alarm) return "R4 period";
    if (m_cnt != 0) return "R3 period";
    if (remote_in) return "R7 period";
    return "R2 period";
  endfunction

  initial begin
    repeat (5) @(negedge clk);
    chk(!sample_strobe && !batt_chk && !cham_chk && !local_alarm && !remote_only,
        "R1 reset outputs", int'(sample_strobe), 0);
    rst = 1'b0;
    wait_sample("R1 first period");
    respond(1'b0);

    // R2 R3 R4 R5 R8: sweep of all six-reading hit patterns
    for (int pat = 0; pat < 64; pat++) begin
      for (int i = 0; i < 6; i++) begin
        wait_sample(tag_for());
        respond(pat[i]);
      end
      while (m_alarm || m_cnt != 0) begin
        wait_sample(tag_for());
        respond(1'b0);
      end
    end

    // R7 R9: remote alarm against the local ladder
    remote_in = 1'b1;
    repeat (2) @(negedge clk);
    chk(remote_only == 1'b1, "R7 flag", int'(remote_only), 1);
    wait_sample("R7 period");
    respond(1'b1);
    wait_sample("R9 ladder over remote");
    respond(1'b0);
    wait_sample("R7 period");
    respond(1'b1);
    wait_sample("R3 period");
    respond(1'b1);
    wait_sample("R3 period");
    respond(1'b1);
    chk(remote_only == 1'b0, "R7 flag in alarm", int'(remote_only), 0);
    wait_sample("R9 alarm over remote");

    // R6 R9: push-button test during an alarm
    pb_test = 1'b1;
    repeat (2) @(negedge clk);
    wait_sample("R6 period");
    respond(1'b1);
    wait_sample("R6 period");
    respond(1'b1);
    wait_sample("R6 fast period");
    respond(1'b0);
    wait_sample("R6 fast period");
    respond(1'b0);
    chk(local_alarm == 1'b1, "R6 ladder kept", int'(local_alarm), 1);
    pb_test = 1'b0;
    m_hits = 0;
    repeat (2) @(negedge clk);
    wait_sample("R9 alarm after test");
    pb_test = 1'b1;
    repeat (2) @(negedge clk);
    wait_sample("R6 hits cleared");
    pb_test = 1'b0;
    repeat (2) @(negedge clk);
    respond(1'b0);
    wait_sample("R5 period");
    respond(1'b1);
    wait_sample("R5 period");
    respond(1'b0);
    wait_sample("R5 period");
    respond(1'b0);
    remote_in = 1'b0;
    repeat (2) @(negedge clk);
    wait_sample("R5 back to standby");
    respond(1'b0);
    for (int k = 0; k < 9; k++) begin
      wait_sample("R8 standby slots");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule